// File: doc/BRIEF.md
# Write-Tracked Register File with Selective Frame Save

This block is a small register file with one write port and one combinational read port. Next to it sits a vector of change flags, one bit per register. An accepted write raises the bit of the register it lands in. A context switch then saves the task's state by issuing a save command. The block walks the flag vector and sends only the changed registers to an external memory. Registers that were not touched since the last switch cost no memory traffic.

Every saved register goes to a fixed slot: the supplied frame base plus its index times the register width in bytes. The frame layout is therefore the same whatever subset was written. A clear command empties the flag vector and is meant as the last step of a switch. A restore command reloads every register from a frame in index order and leaves the flags empty. An optional compare mode raises a flag only when the written value differs from what the register already holds. While a save or restore is running, writes are held off through a ready signal, so the saved data always matches the flag snapshot taken at the start.

Top module: `rtrk_regfile`

## Requirements
- R1: After reset every register reads 0, dirtyFlags is 0, busy and memReq are low and wrReady is high.
- R2: A write accepted at a clock edge (wrEn high while wrReady is high) stores wrData in register wrIdx. The read port shows the new value from the next cycle. With cmpMode low, bit wrIdx of dirtyFlags (bit i belongs to register i) is set from the next cycle.
- R3: With cmpMode high, an accepted write sets its flag only if wrData differs from the register's current value. Rewriting an identical value leaves the flag at 0. The data is stored in both cases.
- R4: A clearReq sampled while idle empties dirtyFlags from the next cycle and leaves register contents alone. A write accepted in the same cycle stores its data, but its flag stays 0.
- R5: A save transfers exactly the registers whose flag was set at the request edge, in ascending index order, each with memWe high and memWdata equal to that register's value. The save leaves dirtyFlags unchanged.
- R6: The transfer for register i uses memAddr = frameBase + i * (DATA_W/8), for both save and restore.
- R7: opDone is high for exactly one cycle. That cycle is the one after the last accepted transfer, or the first cycle after the request when nothing is to be transferred. So a save of p registers with a memory that acknowledges each request after L wait cycles raises opDone p*(L+1)+1 cycles after the request edge. busy is low in the cycle after opDone.
- R8: wrReady is low while a save or restore is running, and also in the idle cycle where saveReq or restoreReq is high. A write held under a low wrReady does not change any register.
- R9: A restore issues one read (memWe low) per register, in order 0 to N-1. It loads each register with memRdata in its acknowledged cycle and raises opDone N*(L+1)+1 cycles after the request edge. dirtyFlags is 0 from the cycle after the request through the end.
- R10: Once memReq is raised, it stays high with memAddr, memWe and memWdata stable until memAck is seen.
- R11: saveReq has priority over restoreReq and clearReq in the same cycle. A clear presented together with a save is ignored, and the flags after that save still equal the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write request |
| wrIdx | input | IDX_W | Register index to write |
| wrData | input | DATA_W | Write data |
| wrReady | output | 1 | Write is accepted at the coming edge when high |
| cmpMode | input | 1 | 1: flag only writes that change the value |
| rdIdx | input | IDX_W | Register index to read |
| rdData | output | DATA_W | Contents of register rdIdx |
| saveReq | input | 1 | Start a selective save (sampled when idle) |
| restoreReq | input | 1 | Start a full restore (sampled when idle) |
| clearReq | input | 1 | Clear all change flags (sampled when idle) |
| frameBase | input | ADDR_W | Base address of the save or restore frame |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | 1: write (save), 0: read (restore) |
| memAddr | output | ADDR_W | Transfer address |
| memWdata | output | DATA_W | Data for a save transfer |
| memAck | input | 1 | Transfer accepted at this edge |
| memRdata | input | DATA_W | Read data, valid with memAck |
| opDone | output | 1 | One-cycle end-of-save or end-of-restore pulse |
| busy | output | 1 | Save or restore in progress |
| dirtyFlags | output | NUM_REGS | Change-flag vector |

## Verification
The bench drives and samples on the falling edge. A written value and its flag bit are expected one cycle after the edge that accepted the write, and a clear is expected to show empty flags one cycle after its request. For save and restore, the bench's memory model acknowledges after a latency chosen per run. The bench predicts opDone exactly p*(L+1)+1 cycles after the request and requires it to be gone, with busy low, one cycle later. Transfers are logged at the falling edge where the acknowledge is raised, so address, direction and data are taken while stable and compared against the ascending list of flagged indices.

// File: rtl/rtrk_pkg.sv
package rtrk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAVE    = 2'd1,
    ST_RESTORE = 2'd2
  } rtrkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrCommit;    // commit the port write this edge
    logic clearAll;    // empty the change-flag vector
    logic loadRestore; // load memRdata into register memIdx
  } rtrkCtl_t;

endpackage

// File: rtl/rtrk_datapath.sv
module rtrk_datapath
  import rtrk_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  rtrkCtl_t            ctl,
  input  logic                cmpMode,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [IDX_W-1:0]    rdIdx,
  output logic [DATA_W-1:0]   rdData,
  input  logic [IDX_W-1:0]    memIdx,
  input  logic [ADDR_W-1:0]   frameBase,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic [NUM_REGS-1:0] flags
);

  localparam int REG_BYTES = DATA_W / 8;

  logic [DATA_W-1:0]   regQ    [NUM_REGS];
  logic [DATA_W-1:0]   regNext [NUM_REGS];
  logic [NUM_REGS-1:0] flagNext;

  // one update slice per register
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    logic hitWr;
    logic hitRst;
    logic changes;
    assign hitWr   = ctl.wrCommit && (wrIdx == IDX_W'(i));
    assign hitRst  = ctl.loadRestore && (memIdx == IDX_W'(i));
    assign changes = (wrData != regQ[i]);
    assign regNext[i] = hitRst ? memRdata : (hitWr ? wrData : regQ[i]);
    assign flagNext[i] = ctl.clearAll ? 1'b0 :
                         ((hitWr && (!cmpMode || changes)) ? 1'b1 : flags[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_REGS; k++) regQ[k] <= '0;
      flags <= '0;
    end else begin
      for (int k = 0; k < NUM_REGS; k++) regQ[k] <= regNext[k];
      flags <= flagNext;
    end
  end

  assign rdData   = regQ[rdIdx];
  assign memWdata = regQ[memIdx];
  assign memAddr  = frameBase + (ADDR_W'(memIdx) * ADDR_W'(REG_BYTES));

  // R4: a clear leaves no flag set, even with a write in the same cycle
  p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearAll |=> (flags == '0));

  // R9: flags stay empty while restore data is loaded
  p_restore_noflag_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadRestore |-> (flags == '0));

  // R8: restore loads and port writes never coincide
  p_no_mixed_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.loadRestore && ctl.wrCommit));

endmodule

// File: rtl/rtrk_control.sv
module rtrk_control
  import rtrk_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                saveReq,
  input  logic                restoreReq,
  input  logic                clearReq,
  input  logic                wrEn,
  input  logic [NUM_REGS-1:0] flags,
  input  logic                memAck,
  output rtrkCtl_t            ctl,
  output logic [IDX_W-1:0]    memIdx,
  output logic                memReq,
  output logic                memWe,
  output logic                busy,
  output logic                wrReady,
  output logic                opDone
);

  localparam int CNT_W = $clog2(NUM_REGS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_REGS);

  rtrkState_e          state;
  logic [NUM_REGS-1:0] pendQ;
  logic [CNT_W-1:0]    cntQ;
  logic                idle;

  function automatic logic [IDX_W-1:0] lowIdx(input logic [NUM_REGS-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (m[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  always_comb begin
    idle    = (state == ST_IDLE);
    busy    = !idle;
    wrReady = idle && !saveReq && !restoreReq;
    memWe   = (state == ST_SAVE);
    memIdx  = (state == ST_RESTORE) ? cntQ[IDX_W-1:0] : lowIdx(pendQ);
    memReq  = ((state == ST_SAVE) && (pendQ != '0)) ||
              ((state == ST_RESTORE) && (cntQ < LAST_CNT));
    opDone  = ((state == ST_SAVE) && (pendQ == '0)) ||
              ((state == ST_RESTORE) && (cntQ == LAST_CNT));
    ctl.wrCommit    = wrEn && wrReady;
    ctl.clearAll    = idle && !saveReq && (restoreReq || clearReq);
    ctl.loadRestore = (state == ST_RESTORE) && memReq && memAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pendQ <= '0;
      cntQ  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (saveReq) begin
            state <= ST_SAVE;
            pendQ <= flags;
          end else if (restoreReq) begin
            state <= ST_RESTORE;
            cntQ  <= '0;
          end
        end
        ST_SAVE: begin
          if (opDone) state <= ST_IDLE;
          else if (memAck) pendQ[memIdx] <= 1'b0;
        end
        ST_RESTORE: begin
          if (opDone) state <= ST_IDLE;
          else if (ctl.loadRestore) cntQ <= cntQ + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: save transfers go to strictly rising indices
  p_ascending_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_SAVE) && memReq && memAck) |=> (!memReq || (memIdx > $past(memIdx))));

  // R10: an unanswered request is held with a stable target
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memIdx) && $stable(memWe)));

  // R7: completion is a single-cycle pulse followed by idle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> (!opDone && !busy));

  // R8: no port write is committed while an operation runs
  p_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctl.wrCommit);

endmodule

// File: rtl/rtrk_regfile.sv
module rtrk_regfile
  import rtrk_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [DATA_W-1:0]   wrData,
  output logic                wrReady,
  input  logic                cmpMode,
  input  logic [IDX_W-1:0]    rdIdx,
  output logic [DATA_W-1:0]   rdData,
  input  logic                saveReq,
  input  logic                restoreReq,
  input  logic                clearReq,
  input  logic [ADDR_W-1:0]   frameBase,
  output logic                memReq,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  input  logic                memAck,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                opDone,
  output logic                busy,
  output logic [NUM_REGS-1:0] dirtyFlags
);

  rtrkCtl_t         ctl;
  logic [IDX_W-1:0] memIdx;

  rtrk_control #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .saveReq    (saveReq),
    .restoreReq (restoreReq),
    .clearReq   (clearReq),
    .wrEn       (wrEn),
    .flags      (dirtyFlags),
    .memAck     (memAck),
    .ctl        (ctl),
    .memIdx     (memIdx),
    .memReq     (memReq),
    .memWe      (memWe),
    .busy       (busy),
    .wrReady    (wrReady),
    .opDone     (opDone)
  );

  rtrk_datapath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                  .IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cmpMode   (cmpMode),
    .wrIdx     (wrIdx),
    .wrData    (wrData),
    .rdIdx     (rdIdx),
    .rdData    (rdData),
    .memIdx    (memIdx),
    .frameBase (frameBase),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .flags     (dirtyFlags)
  );

endmodule

// File: tb/rtrk_regfile_tb.sv
module rtrk_regfile_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int DW = 16;
  localparam int AW = 16;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [IW-1:0] wrIdx = '0;
  logic [DW-1:0] wrData = '0;
  logic          wrReady;
  logic          cmpMode = 1'b0;
  logic [IW-1:0] rdIdx = '0;
  logic [DW-1:0] rdData;
  logic          saveReq = 1'b0;
  logic          restoreReq = 1'b0;
  logic          clearReq = 1'b0;
  logic [AW-1:0] frameBase = '0;
  logic          memReq;
  logic          memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic          memAck = 1'b0;
  logic [DW-1:0] memRdata;
  logic          opDone;
  logic          busy;
  logic [N-1:0]  dirtyFlags;

  rtrk_regfile #(.NUM_REGS(N), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .wrReady(wrReady), .cmpMode(cmpMode), .rdIdx(rdIdx), .rdData(rdData),
    .saveReq(saveReq), .restoreReq(restoreReq), .clearReq(clearReq),
    .frameBase(frameBase), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata),
    .opDone(opDone), .busy(busy), .dirtyFlags(dirtyFlags)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int failures = 0;

  logic [DW-1:0] mem [1024];
  logic [DW-1:0] expReg [N];
  int            latency = 0;
  int            waitCnt = 0;
  int            logCnt = 0;
  logic [AW-1:0] logAddr [32];
  logic [DW-1:0] logData [32];
  logic          logWe [32];

  assign memRdata = mem[memAddr[10:1]];

  // memory model: acknowledge after 'latency' wait cycles, log at the ack
  always @(negedge clk) begin
    if (memReq && rstN) begin
      if (waitCnt >= latency) begin
        memAck = 1'b1;
        waitCnt = 0;
        if (logCnt < 32) begin
          logAddr[logCnt] = memAddr;
          logData[logCnt] = memWdata;
          logWe[logCnt]   = memWe;
        end
        logCnt++;
        if (memWe) mem[memAddr[10:1]] = memWdata;
      end else begin
        memAck = 1'b0;
        waitCnt++;
      end
    end else begin
      memAck = 1'b0;
      waitCnt = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] valOf(input int m, input int i);
    return DW'(m * 37 + i * 101 + 1);
  endfunction

  task automatic doWrite(input int idx, input logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = IW'(idx); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    expReg[idx] = d;
  endtask

  task automatic doClear();
    @(negedge clk);
    clearReq = 1'b1;
    @(negedge clk);
    clearReq = 1'b0;
    #1;
    chk(dirtyFlags == '0, "R4 clear flags", 32'(dirtyFlags), 0);
  endtask

  task automatic checkRead(input int idx, input string tag);
    rdIdx = IW'(idx);
    #1;
    chk(rdData == expReg[idx], tag, 32'(rdData), 32'(expReg[idx]));
  endtask

  task automatic runSave(input int mask, input logic [AW-1:0] base, input int lat,
                         input bit stallWr, input bit withClear);
    int k;
    int p;
    int e;
    bit readyLow;
    latency = lat; logCnt = 0; frameBase = base;
    p = $countones(N'(mask));
    @(negedge clk);
    saveReq = 1'b1; clearReq = withClear;
    #1;
    chk(wrReady == 1'b0, "R8 ready low at request", 32'(wrReady), 0);
    @(negedge clk);
    saveReq = 1'b0; clearReq = 1'b0;
    if (stallWr) begin wrEn = 1'b1; wrIdx = '0; wrData = 16'hBEEF; end
    k = 1;
    readyLow = 1'b1;
    #1;
    while (!opDone && k < 300) begin
      if (wrReady) readyLow = 1'b0;
      @(negedge clk);
      k++;
      #1;
    end
    if (wrReady) readyLow = 1'b0;
    wrEn = 1'b0;
    chk(k == p * (lat + 1) + 1, "R7 save done cycle", 32'(k), 32'(p * (lat + 1) + 1));
    if (stallWr) chk(readyLow, "R8 ready low while busy", 32'(readyLow), 1);
    @(negedge clk);
    #1;
    chk(!opDone && !busy, "R7 single pulse then idle", {30'd0, opDone, busy}, 0);
    chk(logCnt == p, "R5 transfer count", 32'(logCnt), 32'(p));
    e = 0;
    for (int i = 0; i < N; i++) begin
      if (mask[i] && e < logCnt) begin
        chk(logWe[e] == 1'b1, "R5 write direction", 32'(logWe[e]), 1);
        chk(logAddr[e] == base + AW'(2 * i), "R6 slot address", 32'(logAddr[e]),
            32'(base + AW'(2 * i)));
        chk(logData[e] == expReg[i], "R5 saved data", 32'(logData[e]), 32'(expReg[i]));
        e++;
      end
    end
    if (withClear)
      chk(dirtyFlags == N'(mask), "R11 clear ignored under save", 32'(dirtyFlags), 32'(mask));
    else
      chk(dirtyFlags == N'(mask), "R5 flags kept by save", 32'(dirtyFlags), 32'(mask));
    if (stallWr) checkRead(0, "R8 stalled write had no effect");
  endtask

  task automatic runRestore(input logic [AW-1:0] base, input int lat);
    int k;
    bit flagsZero;
    latency = lat; logCnt = 0; frameBase = base;
    for (int i = 0; i < N; i++) mem[(base[10:1]) + 10'(i)] = DW'(16'h5A00 + i * 7 + lat);
    @(negedge clk);
    restoreReq = 1'b1;
    @(negedge clk);
    restoreReq = 1'b0;
    k = 1;
    flagsZero = 1'b1;
    #1;
    while (!opDone && k < 300) begin
      if (dirtyFlags != '0) flagsZero = 1'b0;
      @(negedge clk);
      k++;
      #1;
    end
    chk(flagsZero, "R9 flags empty during restore", 32'(flagsZero), 1);
    chk(k == N * (lat + 1) + 1, "R9 restore done cycle", 32'(k), 32'(N * (lat + 1) + 1));
    chk(logCnt == N, "R9 read count", 32'(logCnt), N);
    for (int i = 0; i < N && i < logCnt; i++) begin
      chk(logWe[i] == 1'b0, "R9 read direction", 32'(logWe[i]), 0);
      chk(logAddr[i] == base + AW'(2 * i), "R6 restore address", 32'(logAddr[i]),
          32'(base + AW'(2 * i)));
    end
    @(negedge clk);
    #1;
    chk(dirtyFlags == '0, "R9 flags empty after restore", 32'(dirtyFlags), 0);
    for (int i = 0; i < N; i++) begin
      expReg[i] = DW'(16'h5A00 + i * 7 + lat);
      checkRead(i, "R9 restored value");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int i = 0; i < N; i++) expReg[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(dirtyFlags == '0, "R1 flags at reset", 32'(dirtyFlags), 0);
    chk(wrReady && !busy && !memReq, "R1 idle at reset", {29'd0, wrReady, busy, memReq}, 32'b100);
    for (int i = 0; i < N; i++) checkRead(i, "R1 register zero at reset");

    // R2 write sweep with accumulating flags
    for (int i = 0; i < N; i++) begin
      doWrite(i, DW'(16'h1000 + i * 3));
      #1;
      checkRead(i, "R2 written value");
      chk(dirtyFlags == N'((1 << (i + 1)) - 1), "R2 flag accumulates", 32'(dirtyFlags),
          32'((1 << (i + 1)) - 1));
    end
    doClear();
    for (int i = 0; i < N; i++) checkRead(i, "R4 data kept by clear");

    // R3 compare mode
    cmpMode = 1'b1;
    doWrite(3, expReg[3]);
    #1;
    chk(dirtyFlags == '0, "R3 same value leaves flag clear", 32'(dirtyFlags), 0);
    doWrite(3, expReg[3] ^ 16'h0001);
    #1;
    chk(dirtyFlags == N'(8), "R3 changed value sets flag", 32'(dirtyFlags), 8);
    checkRead(3, "R3 data stored");
    cmpMode = 1'b0;
    doClear();
    doWrite(5, expReg[5]);
    #1;
    chk(dirtyFlags == N'(32), "R2 same value flagged without compare", 32'(dirtyFlags), 32);

    // R4 clear and write in the same cycle
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 3'd2; wrData = 16'h7777; clearReq = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; clearReq = 1'b0;
    expReg[2] = 16'h7777;
    #1;
    chk(dirtyFlags == '0, "R4 clear wins over same-cycle flag", 32'(dirtyFlags), 0);
    checkRead(2, "R4 same-cycle write stored");

    // R5 R6 R7 R8 R11 sweep over every flag subset
    for (int m = 0; m < 256; m++) begin
      doClear();
      for (int i = 0; i < N; i++) if (m[i]) doWrite(i, valOf(m, i));
      #1;
      chk(dirtyFlags == N'(m), "R2 flags before save", 32'(dirtyFlags), 32'(m));
      runSave(m, AW'(16'h0200 + m * 4), m % 3, (m % 5) == 0, (m % 7) == 3);
    end

    // R9 restore with two latencies
    doWrite(1, 16'h1111);
    runRestore(16'h0100, 0);
    doWrite(6, 16'h6666);
    runRestore(16'h0180, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule